// File: doc/BRIEF.md
# External Parallel Memory Bus Controller

This block sits between an 8-bit core's external data-space load/store port and a set of general-purpose port pins. For each request it first decides, from a programmed memory mode, whether the access belongs to on-chip memory or to an off-chip device. Off-chip accesses run on a parallel bus made of an address high byte, an address low byte, eight data lines, an active-low read strobe, an active-low write strobe and, in multiplexed mode, an address latch-enable strobe. The bus can use either of two pin groups. It can also share the address low byte with the data lines in multiplexed mode.

The controller claims its pins only while an off-chip access is in flight. At every other moment each pin's value and output enable come straight from the port latch inputs. The core sees a `busy` level for the length of an off-chip access and a one-cycle `done` pulse when it ends. On-chip hits are signalled to the on-chip memory through `onchip_hit` and need no bus cycle.

The sequencer is a five-state machine. `ST_IDLE` accepts a request. It goes to `ST_ALE` when multiplexed, otherwise to `ST_SETUP` when the setup count is non-zero, otherwise to `ST_STROBE`. `ST_ALE` lasts one cycle and then goes to `ST_SETUP`, or straight to `ST_STROBE` when setup is zero. `ST_SETUP` counts its cycles and then goes to `ST_STROBE`. `ST_STROBE` counts the strobe width and then goes to `ST_HOLD`, or back to `ST_IDLE` when hold is zero. `ST_HOLD` counts the hold cycles and returns to `ST_IDLE`.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset, `busy` and `done` are low, every pin follows its latch inputs, and the memory mode is on-chip only, so any request raises `onchip_hit`.
- R2: The mode field is config bits [3:2]. The encodings are:
  - 0: every access is on-chip.
  - 1: split, without bank select.
  - 2: split, with bank select.
  - 3: every access is off-chip.

  In the two split modes, addresses below 0x1000 are on-chip and all others are off-chip. `onchip_hit` is high only for an on-chip request while the block is not busy.
- R3: In modes 1 and 3 the bus address is the request address. In mode 2 the bus address high byte is the page register and the low byte is the request's low byte.
- R4: In multiplexed mode (config bit 1 = 1) the first busy cycle raises latch-enable for exactly one cycle, with the address low byte on the data lines and both strobes high.
- R5: The timing register holds setup in bits [1:0], hold in bits [3:2] and strobe width minus one in bits [7:4]. The total number of busy cycles is (1 if multiplexed) + setup + width + hold. The strobe first goes low in busy cycle number (multiplexed) + setup, counting from 0.
- R6: During a read strobe the data-line output enables are low, only the read strobe is low, and `rdata` holds the data lines as sampled in the last strobe cycle.
- R7: During a write strobe the data lines carry the write data with their enables high, and only the write strobe is low.
- R8: While not busy, `pin_out` equals `latch_out` and `pin_oe` equals `latch_oe` on every bit.
- R9: In non-multiplexed mode the address low byte appears on group byte 2, and the latch-enable pin (group bit 29) follows its latch.
- R10: Config bit 0 chooses the group: 0 selects bits [31:0] and 1 selects bits [63:32]. The other group follows its latches throughout. Within a group, the data lines are byte 0, the address high byte is byte 1, write strobe is bit 31, read strobe is bit 30 and latch-enable is bit 29.
- R11: A request or a register write presented while busy is ignored. It neither starts a second access nor changes the mode.
- R12: `done` is high for exactly one cycle, in the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 config, 1 timing, 2 page |
| cfg_wdata | input | 8 | Register write data |
| req | input | 1 | Core external-data request |
| req_we | input | 1 | Request is a write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Request write data |
| onchip_hit | output | 1 | Request routed to on-chip memory |
| busy | output | 1 | Off-chip access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured off-chip read data |
| latch_out | input | 64 | Port latch values for both groups |
| latch_oe | input | 64 | Port latch output enables |
| pin_din | input | 16 | Data-line pad inputs, 8 per group |
| pin_out | output | 64 | Pin output values |
| pin_oe | output | 64 | Pin output enables |

## Verification
The bench aims first at the mode split boundary at 0x0FFF and 0x1000 in every mode. A decoder with an off-by-one limit, or one that ignores the mode, sends accesses to the wrong memory. Next it sweeps the extreme setup, hold and width settings: zero setup with zero hold, and the maximum width of 16. A counter compared against the wrong end value stretches or clips `busy` and moves the strobe edge. It checks that read data comes from the last strobe cycle, while the bench floats different values on the data lines outside the strobe, so a late capture returns the wrong byte. Finally it issues requests and register writes in the middle of an access. A design that accepts them either chains a second access or switches mode under a live bus.

// File: rtl/xm_pkg.sv
package xm_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int NUM_GROUPS = 2;
    localparam int GRP_W      = 4 * DATA_W;
    localparam int PIN_W      = NUM_GROUPS * GRP_W;
    localparam int CNT_W      = 4;

    // byte lanes inside one pin group
    localparam int LANE_DATA  = 0;
    localparam int LANE_AHI   = DATA_W;
    localparam int LANE_ALO   = 2 * DATA_W;
    localparam int BIT_WR     = GRP_W - 1;
    localparam int BIT_RD     = GRP_W - 2;
    localparam int BIT_ALE    = GRP_W - 3;

    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_TIM  = 2'd1;
    localparam logic [1:0] SEL_PAGE = 2'd2;

    typedef enum logic [1:0] {
        MM_ONCHIP     = 2'd0,
        MM_SPLIT      = 2'd1,
        MM_SPLIT_BANK = 2'd2,
        MM_OFFCHIP    = 2'd3
    } xm_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } xm_state_e;

    typedef struct packed {
        xm_mode_e mode;
        logic     mux;
        logic     grp_hi;
    } xm_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] width_m1;
        logic [1:0]       hold;
        logic [1:0]       setup;
    } xm_timing_t;
endpackage

// File: rtl/xm_cfg_regs.sv
module xm_cfg_regs
    import xm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output xm_cfg_t           cfg,
    output xm_timing_t        tim,
    output logic [DATA_W-1:0] page
);
    logic wr_ok;
    assign wr_ok = we && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg  <= '0;
            tim  <= '0;
            page <= '0;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_CFG:  cfg  <= xm_cfg_t'(wdata[3:0]);
                SEL_TIM:  tim  <= xm_timing_t'(wdata);
                SEL_PAGE: page <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/xm_addr_decode.sv
module xm_addr_decode
    import xm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ONCHIP_LIMIT = 16'h1000
) (
    input  xm_mode_e          mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] page,
    output logic              offchip,
    output logic [ADDR_W-1:0] bus_addr
);
    logic above;
    assign above = (addr >= ONCHIP_LIMIT);

    always_comb begin
        bus_addr = addr;
        unique case (mode)
            MM_ONCHIP:     offchip = 1'b0;
            MM_SPLIT:      offchip = above;
            MM_SPLIT_BANK: begin
                offchip  = above;
                bus_addr = {page, addr[DATA_W-1:0]};
            end
            MM_OFFCHIP:    offchip = 1'b1;
            default:       offchip = 1'b0;
        endcase
    end
endmodule

// File: rtl/xm_seq_fsm.sv
module xm_seq_fsm
    import xm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mux,
    input  xm_timing_t        tim,
    input  logic              we,
    input  logic [DATA_W-1:0] rd_in,
    output xm_state_e         state,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    xm_state_e        state_d;
    logic [CNT_W-1:0] cnt, cnt_d;
    logic             last_strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt + 1'b1;
        unique case (state)
            ST_IDLE: begin
                cnt_d = '0;
                if (start)
                    state_d = mux ? ST_ALE
                            : ((tim.setup != 2'd0) ? ST_SETUP : ST_STROBE);
            end
            ST_ALE: begin
                cnt_d   = '0;
                state_d = (tim.setup != 2'd0) ? ST_SETUP : ST_STROBE;
            end
            ST_SETUP: begin
                if (cnt[1:0] == tim.setup - 2'd1) begin
                    state_d = ST_STROBE;
                    cnt_d   = '0;
                end
            end
            ST_STROBE: begin
                if (cnt == tim.width_m1) begin
                    state_d = (tim.hold != 2'd0) ? ST_HOLD : ST_IDLE;
                    cnt_d   = '0;
                end
            end
            ST_HOLD: begin
                if (cnt[1:0] == tim.hold - 2'd1) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign busy        = (state != ST_IDLE);
    assign last_strobe = (state == ST_STROBE) && (cnt == tim.width_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= busy && (state_d == ST_IDLE);
            if (last_strobe && !we)
                rdata <= rd_in;
        end
    end
endmodule

// File: rtl/xm_pin_mux.sv
module xm_pin_mux
    import xm_pkg::*;
(
    input  logic              busy,
    input  logic              grp_hi,
    input  logic              mux,
    input  xm_state_e         state,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PIN_W-1:0]  latch_out,
    input  logic [PIN_W-1:0]  latch_oe,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    localparam logic [DATA_W-1:0] ALL_ON = {DATA_W{1'b1}};

    logic in_ale, in_strb;
    assign in_ale  = (state == ST_ALE);
    assign in_strb = (state == ST_STROBE);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int BASE = g * GRP_W;
        logic             own;
        logic [GRP_W-1:0] g_out, g_oe, l_out, l_oe;

        assign l_out = latch_out[BASE +: GRP_W];
        assign l_oe  = latch_oe[BASE +: GRP_W];
        assign own   = busy && (grp_hi == (g != 0));

        always_comb begin
            g_out = l_out;
            g_oe  = l_oe;
            if (own) begin
                if (mux && in_ale) begin
                    g_out[LANE_DATA +: DATA_W] = addr[DATA_W-1:0];
                    g_oe[LANE_DATA +: DATA_W]  = ALL_ON;
                end else if (we) begin
                    g_out[LANE_DATA +: DATA_W] = wdata;
                    g_oe[LANE_DATA +: DATA_W]  = ALL_ON;
                end else begin
                    g_oe[LANE_DATA +: DATA_W]  = '0;
                end
                g_out[LANE_AHI +: DATA_W] = addr[ADDR_W-1 -: DATA_W];
                g_oe[LANE_AHI +: DATA_W]  = ALL_ON;
                if (!mux) begin
                    g_out[LANE_ALO +: DATA_W] = addr[DATA_W-1:0];
                    g_oe[LANE_ALO +: DATA_W]  = ALL_ON;
                end else begin
                    g_out[BIT_ALE] = in_ale;
                    g_oe[BIT_ALE]  = 1'b1;
                end
                g_out[BIT_WR] = !(in_strb && we);
                g_oe[BIT_WR]  = 1'b1;
                g_out[BIT_RD] = !(in_strb && !we);
                g_oe[BIT_RD]  = 1'b1;
            end
        end

        assign pin_out[BASE +: GRP_W] = g_out;
        assign pin_oe[BASE +: GRP_W]  = g_oe;
    end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ONCHIP_LIMIT = 16'h1000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_sel,
    input  logic [DATA_W-1:0]            cfg_wdata,
    input  logic                         req,
    input  logic                         req_we,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         onchip_hit,
    output logic                         busy,
    output logic                         done,
    output logic [DATA_W-1:0]            rdata,
    input  logic [PIN_W-1:0]             latch_out,
    input  logic [PIN_W-1:0]             latch_oe,
    input  logic [NUM_GROUPS*DATA_W-1:0] pin_din,
    output logic [PIN_W-1:0]             pin_out,
    output logic [PIN_W-1:0]             pin_oe
);
    xm_cfg_t           cfg_q;
    xm_timing_t        tim_q;
    logic [DATA_W-1:0] page_q;
    logic              offchip, start, grp_hi;
    logic [ADDR_W-1:0] bus_addr, acc_addr;
    logic              acc_we;
    logic [DATA_W-1:0] acc_wdata, rd_in;
    xm_state_e         state;

    xm_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .busy  (busy),
        .cfg   (cfg_q),
        .tim   (tim_q),
        .page  (page_q)
    );

    xm_addr_decode #(.ONCHIP_LIMIT(ONCHIP_LIMIT)) u_dec (
        .mode     (cfg_q.mode),
        .addr     (req_addr),
        .page     (page_q),
        .offchip  (offchip),
        .bus_addr (bus_addr)
    );

    assign start      = req && offchip && !busy;
    assign onchip_hit = req && !offchip && !busy;
    assign grp_hi     = cfg_q.grp_hi;
    assign rd_in      = grp_hi ? pin_din[DATA_W +: DATA_W] : pin_din[0 +: DATA_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_addr  <= '0;
            acc_we    <= 1'b0;
            acc_wdata <= '0;
        end else if (start) begin
            acc_addr  <= bus_addr;
            acc_we    <= req_we;
            acc_wdata <= req_wdata;
        end
    end

    xm_seq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .mux   (cfg_q.mux),
        .tim   (tim_q),
        .we    (acc_we),
        .rd_in (rd_in),
        .state (state),
        .busy  (busy),
        .done  (done),
        .rdata (rdata)
    );

    xm_pin_mux u_pins (
        .busy      (busy),
        .grp_hi    (grp_hi),
        .mux       (cfg_q.mux),
        .state     (state),
        .we        (acc_we),
        .addr      (acc_addr),
        .wdata     (acc_wdata),
        .latch_out (latch_out),
        .latch_oe  (latch_oe),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );
endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk
    import xm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             onchip_hit,
    input logic             grp_hi,
    input logic [PIN_W-1:0] latch_out,
    input logic [PIN_W-1:0] latch_oe,
    input logic [PIN_W-1:0] pin_out,
    input logic [PIN_W-1:0] pin_oe
);
    logic [GRP_W-1:0] sel_out, sel_oe, oth_out, oth_oe, oth_lout, oth_loe;

    assign sel_out  = grp_hi ? pin_out[GRP_W +: GRP_W] : pin_out[0 +: GRP_W];
    assign sel_oe   = grp_hi ? pin_oe[GRP_W +: GRP_W]  : pin_oe[0 +: GRP_W];
    assign oth_out  = grp_hi ? pin_out[0 +: GRP_W]     : pin_out[GRP_W +: GRP_W];
    assign oth_oe   = grp_hi ? pin_oe[0 +: GRP_W]      : pin_oe[GRP_W +: GRP_W];
    assign oth_lout = grp_hi ? latch_out[0 +: GRP_W]   : latch_out[GRP_W +: GRP_W];
    assign oth_loe  = grp_hi ? latch_oe[0 +: GRP_W]    : latch_oe[GRP_W +: GRP_W];

    p_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pin_out == latch_out) && (pin_oe == latch_oe));

    p_other_grp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (oth_out == oth_lout) && (oth_oe == oth_loe));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sel_out[BIT_RD] || sel_out[BIT_WR]));

    p_rd_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sel_out[BIT_RD]) |-> (sel_oe[LANE_DATA +: DATA_W] == '0));

    p_onchip_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        onchip_hit |-> !busy);

    p_done_after_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .onchip_hit (onchip_hit),
    .grp_hi     (grp_hi),
    .latch_out  (latch_out),
    .latch_oe   (latch_oe),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
);

// File: tb/xmem_bus_ctrl_bench.sv
module xmem_bus_ctrl_bench;
    localparam time       CLK_HALF = 5ns;
    localparam logic [7:0] RDV     = 8'h3C;
    localparam logic [7:0] IDLEV   = 8'hEE;
    localparam logic [63:0] LOUT   = 64'hF0C3_5AA5_F0C3_5AA5;
    localparam logic [63:0] LOE    = 64'h00FF_0F0F_00FF_0F0F;

    // mode[18:17], addr[16:1], expected on-chip[0]
    localparam logic [18:0] DEC_VEC [0:9] = '{
        {2'd0, 16'hFFFF, 1'b1},
        {2'd0, 16'h1000, 1'b1},
        {2'd1, 16'h0FFF, 1'b1},
        {2'd1, 16'h1000, 1'b0},
        {2'd1, 16'hFFFF, 1'b0},
        {2'd2, 16'h0800, 1'b1},
        {2'd2, 16'h1000, 1'b0},
        {2'd3, 16'h0000, 1'b0},
        {2'd3, 16'h0FFF, 1'b0},
        {2'd2, 16'h0FFF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        onchip_hit, busy, done;
    logic [7:0]  rdata;
    logic [63:0] latch_out = LOUT;
    logic [63:0] latch_oe = LOE;
    logic [15:0] pin_din;
    logic [63:0] pin_out, pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #CLK_HALF clk = ~clk;

    // data lines carry RDV only while that group's read strobe is low
    assign pin_din = {(pin_out[62] ? IDLEV : RDV), (pin_out[30] ? IDLEV : RDV)};

    xmem_bus_ctrl u_xmem_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .onchip_hit(onchip_hit), .busy(busy), .done(done),
        .rdata(rdata), .latch_out(latch_out), .latch_oe(latch_oe),
        .pin_din(pin_din), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic setcfg(input logic [1:0] mode, input logic mux, input logic grp,
                          input int s, input int h, input int wm1, input logic [7:0] page);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = {4'h0, mode, mux, grp};
        @(negedge clk);
        cfg_sel = 2'd1; cfg_wdata = {wm1[3:0], h[1:0], s[1:0]};
        @(negedge clk);
        cfg_sel = 2'd2; cfg_wdata = page;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle(inout int n);
        while (busy && n < 200) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic run_acc(input logic we, input logic [15:0] a, input logic [7:0] wd,
                           input logic [15:0] ea, input logic mux, input logic g,
                           input int s, input int h, input int w);
        int n = 0, ale_n = 0, strb_n = 0, first_strb = -1, ale_idx = -1;
        logic [31:0] go, ge, lo, le, oo, oe_o;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        #1 chk(onchip_hit == 1'b0, "R2 off-chip request", onchip_hit, 0);
        @(negedge clk);
        req = 1'b0;
        #1;
        while (busy && n < 200) begin
            go   = g ? pin_out[63:32] : pin_out[31:0];
            ge   = g ? pin_oe[63:32]  : pin_oe[31:0];
            lo   = g ? LOUT[63:32]    : LOUT[31:0];
            le   = g ? LOE[63:32]     : LOE[31:0];
            oo   = g ? pin_out[31:0]  : pin_out[63:32];
            oe_o = g ? pin_oe[31:0]   : pin_oe[63:32];
            chk(oo == (g ? LOUT[31:0] : LOUT[63:32]) && oe_o == (g ? LOE[31:0] : LOE[63:32]),
                "R10 unselected group follows latch", oo, g ? LOUT[31:0] : LOUT[63:32]);
            if (mux && go[29]) begin
                ale_n++; ale_idx = n;
                chk(go[7:0] == ea[7:0] && ge[7:0] == 8'hFF, "R4 address low on data during ALE",
                    go[7:0], ea[7:0]);
                chk(go[31:30] == 2'b11, "R4 strobes high during ALE", go[31:30], 2'b11);
            end
            if (!mux)
                chk(go[29] == lo[29] && ge[29] == le[29], "R9 ALE pin follows latch",
                    go[29], lo[29]);
            if (!go[30] || !go[31]) begin
                strb_n++;
                if (first_strb < 0) first_strb = n;
                chk(go[15:8] == ea[15:8] && ge[15:8] == 8'hFF, "R3 address high byte",
                    go[15:8], ea[15:8]);
                if (!mux)
                    chk(go[23:16] == ea[7:0] && ge[23:16] == 8'hFF, "R9 address low on byte 2",
                        go[23:16], ea[7:0]);
                if (we) begin
                    chk(go[31:30] == 2'b01, "R7 only write strobe low", go[31:30], 2'b01);
                    chk(go[7:0] == wd && ge[7:0] == 8'hFF, "R7 write data driven", go[7:0], wd);
                end else begin
                    chk(go[31:30] == 2'b10, "R6 only read strobe low", go[31:30], 2'b10);
                    chk(ge[7:0] == 8'h00, "R6 data drivers off on read", ge[7:0], 0);
                end
            end
            n++;
            @(negedge clk); #1;
        end
        chk(n == (mux ? 1 : 0) + s + w + h, "R5 busy length", n, (mux ? 1 : 0) + s + w + h);
        chk(ale_n == (mux ? 1 : 0), "R4 ALE pulse count", ale_n, mux ? 1 : 0);
        if (mux) chk(ale_idx == 0, "R4 ALE in first busy cycle", ale_idx, 0);
        chk(strb_n == w, "R5 strobe width", strb_n, w);
        chk(first_strb == (mux ? 1 : 0) + s, "R5 strobe start after setup", first_strb,
            (mux ? 1 : 0) + s);
        chk(done == 1'b1, "R12 done after busy falls", done, 1);
        chk(pin_out == LOUT && pin_oe == LOE, "R8 pins released", pin_out, LOUT);
        if (!we) chk(rdata == RDV, "R6 read data from last strobe cycle", rdata, RDV);
        @(negedge clk); #1;
        chk(done == 1'b0, "R12 done lasts one cycle", done, 0);
    endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n;
        logic [18:0] v;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(busy == 1'b0, "R1 busy low after reset", busy, 0);
        chk(done == 1'b0, "R1 done low after reset", done, 0);
        chk(pin_out == LOUT && pin_oe == LOE, "R1 R8 pins follow latches", pin_out, LOUT);
        rst_n = 1'b1;
        @(negedge clk);
        req = 1'b1; req_addr = 16'hFFFF;
        #1 chk(onchip_hit == 1'b1, "R1 on-chip-only mode after reset", onchip_hit, 1);
        @(negedge clk);
        req = 1'b0;
        #1 chk(busy == 1'b0, "R1 no access started in reset mode", busy, 0);

        // R2 decode table
        for (int i = 0; i < 10; i++) begin
            v = DEC_VEC[i];
            setcfg(v[18:17], 1'b0, 1'b0, 0, 0, 0, 8'h00);
            req = 1'b1; req_we = 1'b1; req_addr = v[16:1]; req_wdata = 8'h11;
            #1 chk(onchip_hit == v[0], "R2 mode decode", onchip_hit, v[0]);
            @(negedge clk);
            req = 1'b0;
            #1 chk(busy == !v[0], "R2 off-chip starts access", busy, !v[0]);
            n = 0;
            wait_idle(n);
            @(negedge clk);
        end

        // multiplexed write, low group, mode 3
        setcfg(2'd3, 1'b1, 1'b0, 1, 2, 2, 8'h00);
        run_acc(1'b1, 16'h1234, 8'hA7, 16'h1234, 1'b1, 1'b0, 1, 2, 3);
        // multiplexed read, high group, mode 1, zero setup and hold
        setcfg(2'd1, 1'b1, 1'b1, 0, 0, 0, 8'h00);
        run_acc(1'b0, 16'h8001, 8'h00, 16'h8001, 1'b1, 1'b1, 0, 0, 1);
        // non-multiplexed read, low group, banked, max width
        setcfg(2'd2, 1'b0, 1'b0, 3, 1, 15, 8'h5A);
        run_acc(1'b0, 16'h13C7, 8'h00, 16'h5AC7, 1'b0, 1'b0, 3, 1, 16);
        // non-multiplexed write, high group, off-chip only
        setcfg(2'd3, 1'b0, 1'b1, 2, 3, 1, 8'h00);
        run_acc(1'b1, 16'h0042, 8'h96, 16'h0042, 1'b0, 1'b1, 2, 3, 2);

        // R11 request and register write while busy are ignored
        setcfg(2'd3, 1'b0, 1'b0, 0, 0, 3, 8'h00);
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 16'h0100; req_wdata = 8'h55;
        @(negedge clk);
        req_addr = 16'h0000;
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h00;
        #1 chk(busy == 1'b1, "R11 access running", busy, 1);
        chk(onchip_hit == 1'b0, "R11 no on-chip hit while busy", onchip_hit, 0);
        @(negedge clk);
        req = 1'b0; cfg_we = 1'b0;
        #1;
        n = 1;
        wait_idle(n);
        chk(n == 4, "R11 single access length", n, 4);
        @(negedge clk); #1;
        chk(busy == 1'b0, "R11 no second access", busy, 0);
        req = 1'b1; req_we = 1'b0; req_addr = 16'h2000;
        #1 chk(onchip_hit == 1'b0, "R11 mode unchanged by write during busy", onchip_hit, 0);
        @(negedge clk);
        req = 1'b0;
        #1 chk(busy == 1'b1, "R11 off-chip mode still active", busy, 1);
        n = 0;
        wait_idle(n);
        repeat (2) @(negedge clk);
        summary();
    end
endmodule